// File: doc/BRIEF.md
# Multicycle Integer Core (Five Fixed Steps)

This block is a small, non-pipelined 32-bit integer core. It runs four instructions: register add, set-on-less-than against an immediate, word load and word store. The core moves each instruction through five steps, one clock per step, always in the same order. The steps are fetch, decode with register read, execute, memory access and write-back.

Every instruction takes all five cycles, even when a step has no work to do for it. A load is the only instruction that uses every step. The core holds the program counter and a file of 32 general registers. It also holds the registers that carry values from one step to the next.

The core reads instruction words through a read-only port addressed by the program counter. It reaches data memory through a single port with a combinational read and a write strobe. The strobe is sampled on the rising clock edge.

Top module: `mc_core`

## Requirements
- R1: The step sequence is fetch, decode, execute, memory, write-back, then fetch again. Each instruction therefore occupies exactly five cycles, and `imem_addr` changes only at the end of the fetch cycle.
- R2: In the fetch cycle the word on `imem_rdata` is captured from the address `imem_addr`, and the program counter then advances by 4.
- R3: add is encoded as bits[31:26]=0 and bits[5:0]=0x20. Its sources are bits[25:21] and bits[20:16], and its destination is bits[15:11]. It writes the 32-bit wrapping sum of the two sources.
- R4: slti is encoded as opcode 0x0A, with source in bits[25:21], destination in bits[20:16] and immediate in bits[15:0]. The immediate is sign-extended and compared signed. The destination receives 1 when the source is less than the immediate, and 0 otherwise.
- R5: lw (opcode 0x23) and sw (opcode 0x2B) take their base from bits[25:21] and their offset from bits[15:0]. The effective address is the base plus the sign-extended offset, and it appears on `dmem_addr` during the memory cycle.
- R6: sw drives `dmem_we` high for exactly its memory cycle, with `dmem_wdata` set to register bits[20:16]. `dmem_we` is low in every other cycle.
- R7: lw captures `dmem_rdata` in the memory cycle and writes it to register bits[20:16] in the write-back cycle.
- R8: Register 0 reads as zero, and any write to it is discarded.
- R9: While `rst` is high, `imem_addr` is 0 and `dmem_we` is low. The first cycle after reset is a fetch.
- R10: Any other encoding spends five cycles and writes neither a register nor memory. This includes opcode 0 with a function code other than 0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address, valid in the memory cycle |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
The assertions take two things for granted. Instruction memory answers in the same cycle as `imem_addr`. Data memory returns the word at `dmem_addr` combinationally during the memory cycle. The bench's memory arrays meet both conditions, and every access it makes is word aligned. The program loads seed values, exercises signed comparisons with negative immediates, writes to register 0, uses a negative store offset and includes an unrecognised word. A behavioural model in the bench checks the fetch address and the data port on every cycle. The final memory contents are then compared with values worked out by hand.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
    } step_e;

    typedef enum logic [2:0] {
        K_ADD, K_SLTI, K_LW, K_SW, K_NONE
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [RAW-1:0]   src1;
        logic [RAW-1:0]   src2;
        logic [RAW-1:0]   dst;
        logic [XLEN-1:0]  imm;
    } dec_t;

    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        d.src1 = w[25:21];
        d.src2 = w[20:16];
        d.imm  = {{(XLEN-16){w[15]}}, w[15:0]};
        unique case (w[31:26])
            OPC_RTYPE: begin
                d.kind = (w[5:0] == FN_ADD) ? K_ADD : K_NONE;
                d.dst  = w[15:11];
            end
            OPC_SLTI: begin d.kind = K_SLTI; d.dst = w[20:16]; end
            OPC_LW:   begin d.kind = K_LW;   d.dst = w[20:16]; end
            OPC_SW:   begin d.kind = K_SW;   d.dst = '0;       end
            default:  begin d.kind = K_NONE; d.dst = '0;       end
        endcase
        return d;
    endfunction

    function automatic logic writes_reg(input kind_e k);
        return (k == K_ADD) || (k == K_SLTI) || (k == K_LW);
    endfunction
endpackage

// File: rtl/mc_stepper.sv
module mc_stepper
    import mc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output step_e step
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_FETCH;
        end else begin
            unique case (step)
                ST_FETCH:  step <= ST_DECODE;
                ST_DECODE: step <= ST_EXEC;
                ST_EXEC:   step <= ST_MEM;
                ST_MEM:    step <= ST_WB;
                default:   step <= ST_FETCH;
            endcase
        end
    end

    AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        step == ST_WB |=> step == ST_FETCH); // R1
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        step == ST_FETCH |=> step == ST_DECODE); // R1
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] cells [N];

    assign cells[0] = '0;

    for (genvar g = 1; g < N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (we && wa == AW'(g))
                cells[g] <= wd;
        end
    end

    assign rd1 = cells[ra1];
    assign rd2 = cells[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  kind_e            kind,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  imm,
    output logic [XLEN-1:0]  y
);
    logic [XLEN-1:0] sum_ab, sum_ai;
    logic            lt;

    assign sum_ab = a + b;
    assign sum_ai = a + imm;
    assign lt     = $signed(a) < $signed(imm);

    always_comb begin
        unique case (kind)
            K_ADD:       y = sum_ab;
            K_SLTI:      y = {{(XLEN-1){1'b0}}, lt};
            K_LW, K_SW:  y = sum_ai;
            default:     y = '0;
        endcase
    end
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    step_e            step;
    logic [XLEN-1:0]  pc_q;
    logic [31:0]      ir_q;
    dec_t             dec_c, dec_q;
    logic [XLEN-1:0]  a_q, b_q, alu_q, mdr_q;
    logic [XLEN-1:0]  rd1, rd2, alu_y, wb_data;
    logic [RAW-1:0]   wb_addr;
    logic             wb_en;

    mc_stepper u_step (.clk(clk), .rst(rst), .step(step));

    assign dec_c = decode_word(ir_q);

    mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .ra1(dec_c.src1), .ra2(dec_c.src2),
        .rd1(rd1), .rd2(rd2),
        .we(wb_en), .wa(wb_addr), .wd(wb_data)
    );

    mc_alu u_alu (
        .kind(dec_q.kind), .a(a_q), .b(b_q), .imm(dec_q.imm), .y(alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            dec_q <= '{kind: K_NONE, default: '0};
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
            mdr_q <= '0;
        end else begin
            unique case (step)
                ST_FETCH: begin
                    ir_q <= imem_rdata;
                    pc_q <= pc_q + XLEN'(4);
                end
                ST_DECODE: begin
                    dec_q <= dec_c;
                    a_q   <= rd1;
                    b_q   <= rd2;
                end
                ST_EXEC:  alu_q <= alu_y;
                ST_MEM:   if (dec_q.kind == K_LW) mdr_q <= dmem_rdata;
                default:  ;
            endcase
        end
    end

    assign wb_en   = (step == ST_WB) && writes_reg(dec_q.kind);
    assign wb_addr = dec_q.dst;
    assign wb_data = (dec_q.kind == K_LW) ? mdr_q : alu_q;

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_q;
    assign dmem_wdata = b_q;
    assign dmem_we    = (step == ST_MEM) && (dec_q.kind == K_SW);

    AST_WE_ONLY_IN_MEM: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> step == ST_MEM); // R6
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        step == ST_FETCH |=> imem_addr == $past(imem_addr) + 32'd4); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        step != ST_FETCH |=> $stable(imem_addr)); // R1
    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        dec_q.kind == K_NONE && step inside {ST_MEM, ST_WB} |-> !dmem_we && !wb_en); // R10
    AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> step == ST_FETCH && imem_addr == 32'd0); // R9
    AST_RESET_NO_STORE: assert property (@(posedge clk)
        rst |-> !dmem_we); // R9
endmodule

// File: tb/test_mc_core.sv
module test_mc_core;
    localparam int CLK_PERIOD = 10;
    localparam int NINSTR     = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] mmem [64];
    logic [31:0] mregs [32];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_core i_mc_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_add(int rs, int rt, int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, 6'h20};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int mpc;
        logic [31:0] w;
        for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
        dmem[0] = 32'd5;
        dmem[1] = 32'hFFFF_FFFD;
        dmem[2] = 32'h7FFF_FFFF;
        dmem[3] = 32'd40;
        imem[0]  = enc_i(6'h23, 0, 1, 0);      // lw r1,0(r0)
        imem[1]  = enc_i(6'h23, 0, 2, 4);      // lw r2,4(r0)
        imem[2]  = enc_i(6'h23, 0, 3, 8);      // lw r3,8(r0)
        imem[3]  = enc_i(6'h23, 0, 11, 12);    // lw r11,12(r0)
        imem[4]  = enc_add(1, 2, 4);           // r4 = 2
        imem[5]  = enc_i(6'h0A, 2, 5, 0);      // -3 < 0 -> 1
        imem[6]  = enc_i(6'h0A, 1, 6, 5);      // 5 < 5 -> 0
        imem[7]  = enc_i(6'h0A, 2, 8, -2);     // -3 < -2 -> 1
        imem[8]  = enc_i(6'h0A, 1, 7, -1);     // 5 < -1 -> 0
        imem[9]  = enc_add(1, 1, 0);           // write r0 discarded
        imem[10] = 32'hFC00_0000;              // unknown opcode
        imem[11] = enc_add(3, 4, 0) | 32'h1;   // opcode 0, wrong function
        imem[12] = enc_i(6'h2B, 0, 0, 16);     // sw r0,16
        imem[13] = enc_i(6'h2B, 0, 4, 20);
        imem[14] = enc_i(6'h2B, 0, 5, 24);
        imem[15] = enc_i(6'h2B, 0, 6, 28);
        imem[16] = enc_i(6'h2B, 0, 8, 32);
        imem[17] = enc_i(6'h2B, 11, 3, -4);    // addr 36
        imem[18] = enc_i(6'h2B, 0, 7, 44);
        imem[19] = enc_add(3, 3, 9);           // wraps: 0xFFFFFFFE
        imem[20] = enc_i(6'h2B, 0, 9, 48);
        imem[21] = enc_i(6'h23, 11, 10, -16);  // lw r10, 24 -> 1
        for (int i = 0; i < 64; i++) mmem[i] = dmem[i];
        for (int i = 0; i < 32; i++) mregs[i] = 32'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset pc", imem_addr, 32'h0);
        check("R9 reset we", {31'h0, dmem_we}, 32'h0);
        rst = 1'b0;
        mpc = 0;
        w = 32'h0;
        for (int n = 0; n < NINSTR; n++) begin
            for (int s = 0; s < 5; s++) begin
                logic [5:0]  op;
                int          rs, rt, rd;
                logic [31:0] sx, ea;
                logic        is_add, is_slti, is_lw, is_sw;
                op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
                sx = {{16{w[15]}}, w[15:0]};
                is_add  = (op == 6'h00) && (w[5:0] == 6'h20);
                is_slti = (op == 6'h0A);
                is_lw   = (op == 6'h23);
                is_sw   = (op == 6'h2B);
                ea = mregs[rs] + sx;
                // per-cycle comparison of the fetch address (R1, R2)
                check("R1 fetch address", imem_addr, 32'(mpc));
                if (s == 3) begin
                    check("R6 store strobe", {31'h0, dmem_we}, {31'h0, is_sw});
                    if (is_sw || is_lw) check("R5 address", dmem_addr, ea);
                    if (is_sw) check("R6 store data", dmem_wdata, mregs[rt]);
                end else begin
                    check("R6 strobe idle", {31'h0, dmem_we}, 32'h0);
                end
                // advance model over the coming edge
                case (s)
                    0: begin w = imem[mpc[7:2]]; mpc += 4; end
                    3: if (is_sw) mmem[ea[7:2]] = mregs[rt];
                    4: begin
                        if (is_add && rd != 0) mregs[rd] = mregs[rs] + mregs[rt];
                        if (is_slti && rt != 0)
                            mregs[rt] = ($signed(mregs[rs]) < $signed(sx)) ? 32'd1 : 32'd0;
                        if (is_lw && rt != 0) mregs[rt] = mmem[ea[7:2]];
                    end
                    default: ;
                endcase
                @(negedge clk);
            end
        end
        check("R8 r0 store", dmem[4], 32'h0);
        check("R3 add", dmem[5], 32'd2);
        check("R4 slti neg<0", dmem[6], 32'd1);
        check("R4 slti equal", dmem[7], 32'd0);
        check("R4 slti neg imm", dmem[8], 32'd1);
        check("R5 negative offset", dmem[9], 32'h7FFF_FFFF);
        check("R4 slti pos<neg", dmem[11], 32'd0);
        check("R3 wrap", dmem[12], 32'hFFFF_FFFE);
        check("R10 untouched", dmem[10], 32'h0);
        check("R7 load path", mregs[10], 32'd1);
        check("R2 final pc", imem_addr, 32'(NINSTR * 4));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule